// File: doc/BRIEF.md
# LCD Panel Power and Backlight Sequencer

This block drives the two panel-control outputs of a notebook LCD: the backlight enable and the display-on signal. The backlight output is allowed only while the panel supply status input is high and a software backlight enable bit is set. Under those conditions it is either held high or driven as a pulse-width-modulated waveform with a 1 kHz period. A 5-bit duty code selects one of 32 steps.

The display-on output follows the panel supply on the way up only after a coarse delay of 62.5 ms to 125 ms. The delay is measured with a free-running 16 Hz tick, and the output asserts on the second tick seen after the supply rises. On the way down it drops in the same cycle as the supply. A one-cycle write strobe loads the enable bit and the duty code together.

A divider of the system clock forms all timing. The divider makes a step tick at 32 times the PWM rate, and the 16 Hz tick is a fixed number of those steps. The panel supply input is taken to be synchronous to the clock.

Top module: `panel_pwr_seq`

## Requirements
- R1: `bl_out_o` is low in any cycle in which `panel_pwr_i` is low or the stored backlight enable is 0.
- R2: With supply and enable high and an active duty code of 0, `bl_out_o` stays high continuously.
- R3: With supply and enable high and an active duty code N in 1..31, `bl_out_o` is high for the first N steps of every 32-step PWM period. One step is STEP_DIV clocks, so the output is high for N*STEP_DIV clocks out of every 32*STEP_DIV.
- R4: A newly written duty code becomes active only at the next PWM period boundary. The remainder of the current period keeps the old code.
- R5: A clock edge with `wr_en_i` high stores `wr_bl_en_i` as the enable and `wr_duty_i[4:0]` as the pending duty code. The new enable acts on `bl_out_o` from the following cycle.
- R6: After `panel_pwr_i` rises, `disp_on_o` rises on the second 16 Hz tick. A tick occurs every TICK_STEPS steps. The delay is more than one tick interval and at most two.
- R7: `disp_on_o` is low in any cycle in which `panel_pwr_i` is low, with no delay.
- R8: If the supply drops before `disp_on_o` has risen, the pending count is discarded. The next rise starts again from zero ticks.
- R9: While reset is applied, and after it is released, both outputs are low, the enable is 0 and the duty code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| panel_pwr_i | input | 1 | Panel supply status, high when the panel is powered |
| wr_en_i | input | 1 | Write strobe for enable and duty code |
| wr_bl_en_i | input | 1 | Backlight enable value to store |
| wr_duty_i | input | DUTY_W | Duty code to store; 0 selects a steady high output |
| bl_out_o | output | 1 | Backlight enable output, gated and PWM-modulated |
| disp_on_o | output | 1 | Display-on output |

## Verification
The hardest case to reach is a supply drop in the narrow interval after the first 16 Hz tick has been counted and before the second one arrives. The stimulus holds the supply high for exactly one tick interval, which guarantees one tick but never two. It then drops the supply for a cycle and raises it again. The bench then requires the delay that follows to exceed one full tick interval, which is only true if the earlier tick was discarded. A duty write placed in the middle of a period is compared cycle by cycle against a model that switches to the new code only at the period boundary.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  typedef enum logic [1:0] {
    DLY_IDLE = 2'd0,
    DLY_ONE  = 2'd1,
    DLY_ON   = 2'd2
  } dly_state_e;

endpackage

// File: rtl/pseq_timebase.sv
module pseq_timebase #(
  parameter int STEP_DIV   = 3125,
  parameter int TICK_STEPS = 2000,
  parameter int DUTY_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              step_o,
  output logic              wrap_o,
  output logic              tick_o,
  output logic [DUTY_W-1:0] pos_o
);
  localparam int DIV_W = $clog2(STEP_DIV + 1);
  localparam int TK_W  = $clog2(TICK_STEPS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(STEP_DIV - 1);
  localparam logic [TK_W-1:0]  TK_LAST  = TK_W'(TICK_STEPS - 1);

  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [TK_W-1:0]   tk_q, tk_d;
  logic [DUTY_W-1:0] pos_q, pos_d;
  logic              step;

  always_comb begin
    step  = (cnt_q == DIV_LAST);
    cnt_d = step ? '0 : cnt_q + 1'b1;
    pos_d = pos_q;
    tk_d  = tk_q;
    if (step) begin
      pos_d = pos_q + 1'b1;
      tk_d  = (tk_q == TK_LAST) ? '0 : tk_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tk_q  <= '0;
      pos_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (step) begin
        tk_q  <= tk_d;
        pos_q <= pos_d;
      end
    end
  end

  assign step_o = step;
  assign wrap_o = step && (pos_q == '1);
  assign tick_o = step && (tk_q == TK_LAST);
  assign pos_o  = pos_q;

  // R3: the step position advances by one on every step tick
  p_pos_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (pos_q == DUTY_W'($past(pos_q) + 1'b1)));

  // R3: the step position holds between step ticks
  p_pos_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pos_q));

endmodule

// File: rtl/pseq_pwm.sv
module pseq_pwm #(
  parameter int DUTY_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap_i,
  input  logic [DUTY_W-1:0] pos_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              hi_o
);
  logic [DUTY_W-1:0] duty_act_q, duty_act_d;

  always_comb begin
    duty_act_d = wrap_i ? duty_i : duty_act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_act_q <= '0;
    end else if (wrap_i) begin
      duty_act_q <= duty_act_d;
    end
  end

  assign hi_o = (duty_act_q == '0) || (pos_i < duty_act_q);

  // R4: the active duty code changes only at a period boundary
  p_duty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(duty_act_q));

  // R3: a period always starts with the output high
  p_period_start_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> hi_o);

endmodule

// File: rtl/pseq_disp_delay.sv
module pseq_disp_delay
  import panel_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_i,
  input  logic tick_i,
  output logic disp_o
);
  dly_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!pwr_i) begin
      st_d = DLY_IDLE;
    end else begin
      case (st_q)
        DLY_IDLE: if (tick_i) st_d = DLY_ONE;
        DLY_ONE:  if (tick_i) st_d = DLY_ON;
        DLY_ON:   st_d = DLY_ON;
        default:  st_d = DLY_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= DLY_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign disp_o = pwr_i && (st_q == DLY_ON);

  // R6: the on state is entered only on a tick
  p_on_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == DLY_ON) |-> $past(tick_i));

  // R8: a supply drop clears any count in progress
  p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_i |=> (st_q == DLY_IDLE));

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq #(
  parameter int STEP_DIV   = 3125,
  parameter int TICK_STEPS = 2000,
  parameter int DUTY_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              panel_pwr_i,
  input  logic              wr_en_i,
  input  logic              wr_bl_en_i,
  input  logic [DUTY_W-1:0] wr_duty_i,
  output logic              bl_out_o,
  output logic              disp_on_o
);
  logic              rst_s1_q, rst_i;
  logic              en_q, en_d;
  logic [DUTY_W-1:0] duty_q, duty_d;
  logic              step, wrap, tick, pwm_hi;
  logic [DUTY_W-1:0] pos;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_i    <= rst_s1_q;
    end
  end

  always_comb begin
    en_d   = wr_en_i ? wr_bl_en_i : en_q;
    duty_d = wr_en_i ? wr_duty_i  : duty_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      en_q   <= 1'b0;
      duty_q <= '0;
    end else if (wr_en_i) begin
      en_q   <= en_d;
      duty_q <= duty_d;
    end
  end

  pseq_timebase #(
    .STEP_DIV  (STEP_DIV),
    .TICK_STEPS(TICK_STEPS),
    .DUTY_W    (DUTY_W)
  ) u_timebase (
    .clk   (clk),
    .rst_n (rst_i),
    .step_o(step),
    .wrap_o(wrap),
    .tick_o(tick),
    .pos_o (pos)
  );

  pseq_pwm #(
    .DUTY_W(DUTY_W)
  ) u_pwm (
    .clk   (clk),
    .rst_n (rst_i),
    .wrap_i(wrap),
    .pos_i (pos),
    .duty_i(duty_q),
    .hi_o  (pwm_hi)
  );

  pseq_disp_delay u_delay (
    .clk   (clk),
    .rst_n (rst_i),
    .pwr_i (panel_pwr_i),
    .tick_i(tick),
    .disp_o(disp_on_o)
  );

  assign bl_out_o = panel_pwr_i && en_q && pwm_hi;

  // R1: no backlight without supply and enable
  p_bl_gate_r1: assert property (@(posedge clk) disable iff (!rst_i)
    (!panel_pwr_i || !en_q) |-> !bl_out_o);

  // R7: display-on is low whenever the supply is low
  p_disp_drop_r7: assert property (@(posedge clk) disable iff (!rst_i)
    !panel_pwr_i |-> !disp_on_o);

  // R5: a write stores the enable value
  p_wr_load_r5: assert property (@(posedge clk) disable iff (!rst_i)
    wr_en_i |=> (en_q == $past(wr_bl_en_i)));

  // R3: the step tick is a single-cycle strobe
  p_step_pulse_r3: assert property (@(posedge clk) disable iff (!rst_i)
    step |=> !step || (STEP_DIV == 1));

endmodule

// File: tb/panel_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module panel_pwr_seq_tb_top;
  localparam int DIV  = 4;
  localparam int TICK = 20;
  localparam int P    = DIV * TICK;
  localparam int PER  = DIV * 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_bl = 1'b0;
  logic [4:0] wr_duty = 5'd0;
  logic       bl_out, disp_on;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  panel_pwr_seq #(.STEP_DIV(DIV), .TICK_STEPS(TICK), .DUTY_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .panel_pwr_i(pwr), .wr_en_i(wr_en),
    .wr_bl_en_i(wr_bl), .wr_duty_i(wr_duty),
    .bl_out_o(bl_out), .disp_on_o(disp_on));

  // behavioural reference model
  int m_e, m_ticks, m_duty, m_act;
  bit m_en, m_s1, m_s2, m_s2_old;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_e = 0; m_ticks = 0; m_duty = 0; m_act = 0; m_en = 0;
      m_s1 = 0; m_s2 = 0;
    end else begin
      m_s2_old = m_s2;
      m_s2 = m_s1;
      m_s1 = 1;
      if (m_s2_old) begin
        m_e = m_e + 1;
        if (m_e % PER == 0) m_act = m_duty;
        if (!pwr) m_ticks = 0;
        else if ((m_e % P == 0) && m_ticks < 2) m_ticks = m_ticks + 1;
        if (wr_en) begin
          m_en = wr_bl;
          m_duty = wr_duty;
        end
      end
    end
  end

  function automatic bit exp_bl();
    int pos;
    pos = (m_e / DIV) % 32;
    return pwr && m_en && ((m_act == 0) || (pos < m_act));
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      string tb, td;
      bit eb, ed;
      eb = exp_bl();
      ed = pwr && (m_ticks >= 2);
      if (!pwr || !m_en)         tb = "R1";
      else if (m_act == 0)       tb = "R2";
      else if (m_act != m_duty)  tb = "R4";
      else                       tb = "R3";
      td = pwr ? "R6" : "R7";
      check(bl_out === eb, tb, "bl_out", int'(bl_out), int'(eb));
      check(disp_on === ed, td, "disp_on", int'(disp_on), int'(ed));
    end
  end

  task automatic drive_edge();
    @(posedge clk);
    #2;
  endtask

  task automatic write_reg(input bit en, input int duty);
    drive_edge();
    wr_en = 1'b1; wr_bl = en; wr_duty = 5'(duty);
    drive_edge();
    wr_en = 1'b0;
  endtask

  task automatic measure_on(input string tag);
    int n;
    n = 0;
    while (n < 3 * P) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (disp_on) break;
    end
    check((n > P) && (n <= 2 * P), tag, "display-on delay cycles", n, P + 1);
  endtask

  task automatic count_high(input int duty);
    int hi;
    hi = 0;
    for (int k = 0; k < PER; k++) begin
      @(negedge clk);
      if (bl_out) hi++;
    end
    check(hi == duty * DIV, "R3", "high clocks per period", hi, duty * DIV);
  endtask

  initial begin
    cmp_on = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(bl_out === 1'b0 && disp_on === 1'b0, "R9", "outputs in reset",
          int'(bl_out) + int'(disp_on), 0);
    drive_edge();
    rst_n = 1'b1;
    repeat (4) drive_edge();
    check(bl_out === 1'b0 && disp_on === 1'b0, "R9", "outputs after reset",
          int'(bl_out) + int'(disp_on), 0);

    // R6: supply rise, enable still 0 (R1)
    drive_edge();
    pwr = 1'b1;
    measure_on("R6");
    check(bl_out === 1'b0, "R1", "bl with enable 0", int'(bl_out), 0);

    // R5, R2: enable with duty 0
    drive_edge();
    wr_en = 1'b1; wr_bl = 1'b1; wr_duty = 5'd0;
    @(negedge clk);
    check(bl_out === 1'b0, "R5", "bl before write edge", int'(bl_out), 0);
    @(negedge clk);
    wr_en = 1'b0;
    check(bl_out === 1'b1, "R5", "bl after write edge", int'(bl_out), 1);
    count_high(32);

    // R4, R3: duty changes mid-period
    repeat (PER / 2 + 3) drive_edge();
    write_reg(1'b1, 8);
    repeat (2 * PER) drive_edge();
    count_high(8);
    write_reg(1'b1, 31);
    repeat (7) drive_edge();
    write_reg(1'b1, 1);
    repeat (2 * PER) drive_edge();
    count_high(1);
    write_reg(1'b1, 31);
    repeat (2 * PER) drive_edge();
    count_high(31);

    // R7, R1: supply drop
    drive_edge();
    pwr = 1'b0;
    @(negedge clk);
    check(disp_on === 1'b0, "R7", "disp same cycle as drop", int'(disp_on), 0);
    check(bl_out === 1'b0, "R1", "bl same cycle as drop", int'(bl_out), 0);
    repeat (5) drive_edge();

    // R8: drop after first tick, before second
    pwr = 1'b1;
    repeat (P) drive_edge();
    check(disp_on === 1'b0, "R8", "disp before second tick", int'(disp_on), 0);
    pwr = 1'b0;
    drive_edge();
    pwr = 1'b1;
    measure_on("R8");

    // R1: enable cleared while powered
    write_reg(1'b0, 12);
    repeat (PER) drive_edge();
    check(bl_out === 1'b0, "R1", "bl with enable cleared", int'(bl_out), 0);
    repeat (4) drive_edge();

    cmp_on = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule